// File: doc/BRIEF.md
# Half-Word Host Port Master

This block lets FPGA logic reach a processor's 16-bit host port. A user issues one 32-bit operation at a time over a request/acknowledge handshake. The operation can be a control-register write, an address-register write, a data write or a data read. The block turns each operation into two strobed half-word bus cycles: the upper half goes first and the lower half second, and a half-select line marks which half is on the bus. A 2-bit register-select field tells the target which register the cycle addresses.

Right after reset, and before it accepts any request, the master programs the target's control register. The control word it writes has its reserved bits at their required values (0x0048 by default). Normal traffic is then an address write followed by one or more data writes or reads.

Each strobe cycle has a setup phase, an active phase and a hold phase, and each phase length is a parameter in clock cycles. The target's wait input can stretch only the active phase of the second half of a data access, because that is the point where the target launches its internal transfer. Control and address cycles never wait.

Top module: `hpm_master`

## Requirements
- R1: While reset is asserted, the chip select and both strobes are high, acknowledge is low, and the host does not drive the data bus.
- R2: After reset and before serving any request, the master performs two strobed writes to the control register (select 00), each carrying INIT_WORD (default 0x0048), with the half line at 0 for the first and 1 for the second.
- R3: Each 32-bit value is transferred as two half-word cycles: bits 31:16 with the half line low, then bits 15:0 with the half line high.
- R4: The select field is 00 for control, 10 for address, 01 for data with address post-increment (addr_inc=1) and 11 for data at a fixed address (addr_inc=0).
- R5: During writes, rw is low and the host drives the half-word on the bus. The second strobe stays high at all times, and chip select is low whenever the first strobe is low.
- R6: A read drives rw high and never drives the bus from the host. It returns {first half, second half} on rdata, valid while ack is high.
- R7: The strobe is low for ACTIVE_CYC cycles when there is no wait. It is high for exactly SETUP_CYC+HOLD_CYC+1 cycles between the two halves of an access. Select, half, rw and write data stay stable while the strobe is low.
- R8: The wait input has no effect on control cycles, address cycles, or the first half of a data access.
- R9: In the second half of a data access, the strobe stays low beyond ACTIVE_CYC until the wait input is sampled low. The strobe rises one cycle after that sample.
- R10: Operation codes are 0 control, 1 address, 2 write data and 3 read data. An operation is accepted while req is high and the master is idle. ack is a single-cycle pulse after the second half-word's hold phase, and req must be held until ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Operation request |
| op | input | 2 | Operation code (R10) |
| wdata | input | 32 | Value to write |
| addr_inc | input | 1 | Data access uses post-increment select |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result |
| hp_cs_n | output | 1 | Chip select, active low |
| hp_rw | output | 1 | 1 = read, 0 = write |
| hp_hhwil | output | 1 | Half line: 0 upper half, 1 lower half |
| hp_sel | output | 2 | Register select |
| hp_stb1_n | output | 1 | Active data strobe |
| hp_stb2_n | output | 1 | Second strobe, held high |
| hp_wait | input | 1 | Target wait request, high = stall |
| hp_data | inout | 16 | Bidirectional half-word bus |

## Verification
The bench starts an address write the moment reset is released. This shows that the control-register programming comes first, and that its word lands in both halves. Write values use different upper and lower halves, so a swapped half order or a wrong half line shows up as a data mismatch. Each of the four select codes is used once. The wait line is driven in three patterns: held high during control and address cycles, held high only during first halves, and raised for a counted number of cycles in a second half. These patterns separate wait that is correctly ignored from wait that stretches the wrong phase. Reads with distinct upper and lower target values confirm the assembly order and that the host releases the bus.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
    typedef enum logic [1:0] {
        OP_CTRL  = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WDATA = 2'd2,
        OP_RDATA = 2'd3
    } hpm_op_e;

    localparam logic [1:0] SEL_CTRL = 2'b00;
    localparam logic [1:0] SEL_DINC = 2'b01;
    localparam logic [1:0] SEL_ADDR = 2'b10;
    localparam logic [1:0] SEL_DFIX = 2'b11;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_ACTIVE, PH_HOLD
    } hpm_phase_e;

    typedef enum logic [2:0] {
        TX_BOOT, TX_IDLE, TX_LAUNCH, TX_WAIT, TX_ACK
    } hpm_txn_e;
endpackage

// File: rtl/hpm_strobe_gen.sv
module hpm_strobe_gen
    import hpm_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int ACTIVE_CYC = 3,
    parameter int HOLD_CYC   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wait_en,
    input  logic wait_i,
    output logic stb_n,
    output logic capture,
    output logic done
);
    localparam int MAX_AB = (SETUP_CYC > ACTIVE_CYC) ? SETUP_CYC : ACTIVE_CYC;
    localparam int MAX_C  = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        hpm_phase_e       ph;
        logic [CNT_W-1:0] cnt;
    } stb_st_t;

    stb_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        capture = 1'b0;
        done    = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph  = PH_SETUP;
                    st_d.cnt = CNT_W'(SETUP_CYC - 1);
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_ACTIVE;
                    st_d.cnt = CNT_W'(ACTIVE_CYC - 1);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_ACTIVE: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else if (!(wait_en && wait_i)) begin
                    capture  = 1'b1;
                    st_d.ph  = PH_HOLD;
                    st_d.cnt = CNT_W'(HOLD_CYC - 1);
                end
            end
            PH_HOLD: begin
                if (st_q.cnt == '0) begin
                    done    = 1'b1;
                    st_d.ph = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ph  <= PH_IDLE;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_n = (st_q.ph != PH_ACTIVE);
endmodule

// File: rtl/hpm_txn_ctrl.sv
module hpm_txn_ctrl
    import hpm_pkg::*;
#(
    parameter int              DW        = 16,
    parameter logic [DW-1:0]   INIT_WORD = 16'h0048
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  hpm_op_e         op_i,
    input  logic [2*DW-1:0] wdata,
    input  logic            addr_inc,
    output logic            ack,
    output logic [2*DW-1:0] rdata,
    output logic            start,
    input  logic            done,
    input  logic            capture,
    input  logic [DW-1:0]   bus_in,
    output logic            cs_n,
    output logic            rw,
    output logic            hhwil,
    output logic [1:0]      sel,
    output logic [DW-1:0]   dout,
    output logic            oe,
    output logic            wait_en
);
    typedef struct packed {
        hpm_txn_e        st;
        hpm_op_e         op;
        logic [2*DW-1:0] word;
        logic            inc;
        logic            half;
        logic            init;
        logic [2*DW-1:0] rdata;
    } txn_st_t;

    txn_st_t tx_d, tx_q;

    always_comb begin
        tx_d  = tx_q;
        ack   = 1'b0;
        start = 1'b0;
        case (tx_q.st)
            TX_BOOT: begin
                tx_d.st   = TX_LAUNCH;
                tx_d.op   = OP_CTRL;
                tx_d.word = {INIT_WORD, INIT_WORD};
                tx_d.init = 1'b1;
                tx_d.half = 1'b0;
            end
            TX_IDLE: begin
                if (req) begin
                    tx_d.st   = TX_LAUNCH;
                    tx_d.op   = op_i;
                    tx_d.word = wdata;
                    tx_d.inc  = addr_inc;
                    tx_d.half = 1'b0;
                end
            end
            TX_LAUNCH: begin
                start   = 1'b1;
                tx_d.st = TX_WAIT;
            end
            TX_WAIT: begin
                if (capture && tx_q.op == OP_RDATA) begin
                    if (tx_q.half) tx_d.rdata[DW-1:0]    = bus_in;
                    else           tx_d.rdata[2*DW-1:DW] = bus_in;
                end
                if (done) begin
                    if (!tx_q.half) begin
                        tx_d.half = 1'b1;
                        tx_d.st   = TX_LAUNCH;
                    end else if (tx_q.init) begin
                        tx_d.init = 1'b0;
                        tx_d.st   = TX_IDLE;
                    end else begin
                        tx_d.st   = TX_ACK;
                    end
                end
            end
            TX_ACK: begin
                ack     = 1'b1;
                tx_d.st = TX_IDLE;
            end
            default: tx_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q.st    <= TX_BOOT;
            tx_q.op    <= OP_CTRL;
            tx_q.word  <= '0;
            tx_q.inc   <= 1'b0;
            tx_q.half  <= 1'b0;
            tx_q.init  <= 1'b0;
            tx_q.rdata <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    always_comb begin
        case (tx_q.op)
            OP_CTRL: sel = SEL_CTRL;
            OP_ADDR: sel = SEL_ADDR;
            default: sel = tx_q.inc ? SEL_DINC : SEL_DFIX;
        endcase
    end

    assign cs_n    = (tx_q.st == TX_BOOT) || (tx_q.st == TX_IDLE) || (tx_q.st == TX_ACK);
    assign rw      = (tx_q.op == OP_RDATA);
    assign hhwil   = tx_q.half;
    assign dout    = tx_q.half ? tx_q.word[DW-1:0] : tx_q.word[2*DW-1:DW];
    assign oe      = !cs_n && !rw;
    assign wait_en = tx_q.half && ((tx_q.op == OP_WDATA) || (tx_q.op == OP_RDATA));
    assign rdata   = tx_q.rdata;
endmodule

// File: rtl/hpm_master.sv
module hpm_master
    import hpm_pkg::*;
#(
    parameter int                 HALF_W     = 16,
    parameter int                 SETUP_CYC  = 2,
    parameter int                 ACTIVE_CYC = 3,
    parameter int                 HOLD_CYC   = 1,
    parameter logic [HALF_W-1:0]  INIT_WORD  = 16'h0048
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [1:0]          op,
    input  logic [2*HALF_W-1:0] wdata,
    input  logic                addr_inc,
    output logic                ack,
    output logic [2*HALF_W-1:0] rdata,
    output logic                hp_cs_n,
    output logic                hp_rw,
    output logic                hp_hhwil,
    output logic [1:0]          hp_sel,
    output logic                hp_stb1_n,
    output logic                hp_stb2_n,
    input  logic                hp_wait,
    inout  wire  [HALF_W-1:0]   hp_data
);
    logic              start, done, capture, wait_en, oe;
    logic [HALF_W-1:0] dout;

    hpm_txn_ctrl #(
        .DW        (HALF_W),
        .INIT_WORD (INIT_WORD)
    ) u_txn (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .op_i     (hpm_op_e'(op)),
        .wdata    (wdata),
        .addr_inc (addr_inc),
        .ack      (ack),
        .rdata    (rdata),
        .start    (start),
        .done     (done),
        .capture  (capture),
        .bus_in   (hp_data),
        .cs_n     (hp_cs_n),
        .rw       (hp_rw),
        .hhwil    (hp_hhwil),
        .sel      (hp_sel),
        .dout     (dout),
        .oe       (oe),
        .wait_en  (wait_en)
    );

    hpm_strobe_gen #(
        .SETUP_CYC  (SETUP_CYC),
        .ACTIVE_CYC (ACTIVE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) u_stb (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wait_en (wait_en),
        .wait_i  (hp_wait),
        .stb_n   (hp_stb1_n),
        .capture (capture),
        .done    (done)
    );

    assign hp_stb2_n = 1'b1;
    assign hp_data   = oe ? dout : {HALF_W{1'bz}};
endmodule

// File: rtl/hpm_master_chk.sv
module hpm_master_chk #(
    parameter int HALF_W     = 16,
    parameter int ACTIVE_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              hp_cs_n,
    input logic              hp_rw,
    input logic              hp_hhwil,
    input logic [1:0]        hp_sel,
    input logic              hp_stb1_n,
    input logic [HALF_W-1:0] hp_data
);
    localparam int CW = $clog2(ACTIVE_CYC + 1);

    logic [CW-1:0] act_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                                  act_cnt <= '0;
        else if (hp_stb1_n)                          act_cnt <= '0;
        else if (act_cnt < CW'(ACTIVE_CYC))          act_cnt <= act_cnt + 1'b1;
    end

    // R5
    stb_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hp_stb1_n |-> !hp_cs_n);

    // R7
    lines_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hp_stb1_n && $past(!hp_stb1_n)) |->
            ($stable(hp_sel) && $stable(hp_hhwil) && $stable(hp_rw) && $stable(hp_cs_n)));

    // R7
    wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hp_stb1_n && $past(!hp_stb1_n) && !hp_rw) |-> $stable(hp_data));

    // R8
    no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hp_stb1_n && (!hp_sel[0] || !hp_hhwil)) |-> (act_cnt < CW'(ACTIVE_CYC)));

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

bind hpm_master hpm_master_chk #(
    .HALF_W     (HALF_W),
    .ACTIVE_CYC (ACTIVE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .hp_cs_n   (hp_cs_n),
    .hp_rw     (hp_rw),
    .hp_hhwil  (hp_hhwil),
    .hp_sel    (hp_sel),
    .hp_stb1_n (hp_stb1_n),
    .hp_data   (hp_data)
);

// File: tb/tb_hpm_master.sv
`timescale 1ns/1ps
module tb_hpm_master;
    localparam int SETUP  = 2;
    localparam int ACTIVE = 3;
    localparam int HOLD   = 1;
    localparam int GAP    = SETUP + HOLD + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [31:0] wdata = '0;
    logic        addr_inc = 1'b0;
    logic        ack;
    logic [31:0] rdata;
    logic        hp_cs_n, hp_rw, hp_hhwil, hp_stb1_n, hp_stb2_n;
    logic [1:0]  hp_sel;
    logic        hp_wait = 1'b0;
    wire  [15:0] hp_data;

    logic [31:0] rd_val = '0;
    int          wait_cycles = 0;
    logic        wait_all = 1'b0;
    logic        wait_first = 1'b0;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    hpm_master #(
        .HALF_W(16), .SETUP_CYC(SETUP), .ACTIVE_CYC(ACTIVE), .HOLD_CYC(HOLD), .INIT_WORD(16'h0048)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op), .wdata(wdata), .addr_inc(addr_inc),
        .ack(ack), .rdata(rdata), .hp_cs_n(hp_cs_n), .hp_rw(hp_rw), .hp_hhwil(hp_hhwil),
        .hp_sel(hp_sel), .hp_stb1_n(hp_stb1_n), .hp_stb2_n(hp_stb2_n), .hp_wait(hp_wait),
        .hp_data(hp_data)
    );

    // target model drives the bus only while a read strobe is low
    assign hp_data = (!hp_cs_n && hp_rw && !hp_stb1_n) ?
                     (hp_hhwil ? rd_val[15:0] : rd_val[31:16]) : 16'hzzzz;

    logic [1:0]  l_sel  [64];
    logic        l_hw   [64];
    logic        l_rw   [64];
    logic [15:0] l_data [64];
    int          l_width[64];
    int          l_gap  [64];
    int          n_log = 0;
    int          low_cnt = 0, hi_cnt = 0, wait_left = 0;
    logic        prev_low = 1'b0;
    int          stab_err = 0, z_err = 0, stb2_err = 0, cs_err = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_low = 1'b0;
            hi_cnt   = 0;
            hp_wait  = 1'b0;
        end else begin
            if (hp_stb2_n !== 1'b1) stb2_err++;
            if (!hp_stb1_n) begin
                if (hp_cs_n !== 1'b0) cs_err++;
                if (!prev_low) begin
                    if (n_log < 64) begin
                        l_sel[n_log]  = hp_sel;
                        l_hw[n_log]   = hp_hhwil;
                        l_rw[n_log]   = hp_rw;
                        l_data[n_log] = hp_data;
                        l_gap[n_log]  = hi_cnt;
                        l_width[n_log] = 0;
                        n_log++;
                    end
                    low_cnt   = 1;
                    wait_left = wait_cycles;
                end else begin
                    low_cnt++;
                    if (wait_left > 0) wait_left--;
                    if (n_log > 0 && (hp_sel !== l_sel[n_log-1] || hp_hhwil !== l_hw[n_log-1] ||
                        hp_rw !== l_rw[n_log-1] || hp_data !== l_data[n_log-1])) stab_err++;
                end
            end else begin
                if (prev_low) begin
                    if (n_log > 0) l_width[n_log-1] = low_cnt;
                    hi_cnt = 1;
                end else begin
                    hi_cnt++;
                end
                if (!hp_cs_n && hp_rw && hp_data !== 16'hzzzz) z_err++;
            end
            prev_low = !hp_stb1_n;
            hp_wait = wait_all || (wait_first && !hp_hhwil) ||
                      (!hp_stb1_n && hp_sel[0] && hp_hhwil && wait_left > 0);
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_half(input string tag, input int idx, input logic [1:0] sel,
                              input logic hw, input logic rw, input logic [15:0] data, input int width);
        check({tag, " sel"},   {30'd0, l_sel[idx]}, {30'd0, sel});
        check({tag, " half"},  {31'd0, l_hw[idx]},  {31'd0, hw});
        check({tag, " rw"},    {31'd0, l_rw[idx]},  {31'd0, rw});
        check({tag, " data"},  {16'd0, l_data[idx]}, {16'd0, data});
        check({tag, " width"}, l_width[idx], width);
    endtask

    task automatic do_op(input logic [1:0] o, input logic [31:0] v, input logic inc,
                         output logic [31:0] rd);
        int n;
        @(negedge clk);
        req = 1'b1; op = o; wdata = v; addr_inc = inc;
        n = 0;
        while (ack !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        rd = rdata;
        check("R10 ack seen", {31'd0, ack}, 32'd1);
        req = 1'b0;
        @(negedge clk);
        check("R10 ack single pulse", {31'd0, ack}, 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 cs_n in reset",  {31'd0, hp_cs_n},   32'd1);
        check("R1 stb1_n in reset", {31'd0, hp_stb1_n}, 32'd1);
        check("R1 stb2_n in reset", {31'd0, hp_stb2_n}, 32'd1);
        check("R1 ack in reset",   {31'd0, ack},       32'd0);
        check("R1 bus released",   {16'd0, hp_data},   {16'd0, 16'hzzzz});
    endtask

    task automatic t_init_addr();
        logic [31:0] rd;
        rst_n = 1'b1;
        do_op(2'd1, 32'h8001_0A5C, 1'b0, rd);
        check("R2 strobe count", n_log, 4);
        check_half("R2 init first",  0, 2'b00, 1'b0, 1'b0, 16'h0048, ACTIVE);
        check_half("R2 init second", 1, 2'b00, 1'b1, 1'b0, 16'h0048, ACTIVE);
        check_half("R3 R4 addr upper", 2, 2'b10, 1'b0, 1'b0, 16'h8001, ACTIVE);
        check_half("R3 R4 addr lower", 3, 2'b10, 1'b1, 1'b0, 16'h0A5C, ACTIVE);
        check("R7 init gap", l_gap[1], GAP);
        check("R7 addr gap", l_gap[3], GAP);
    endtask

    task automatic t_write_inc_wait();
        logic [31:0] rd;
        int b;
        b = n_log;
        wait_cycles = 7;
        do_op(2'd2, 32'h1234_5678, 1'b1, rd);
        wait_cycles = 0;
        check_half("R3 R4 R5 R8 wr inc upper", b,   2'b01, 1'b0, 1'b0, 16'h1234, ACTIVE);
        check_half("R3 R4 R5 R9 wr inc lower", b+1, 2'b01, 1'b1, 1'b0, 16'h5678, 8);
        check("R7 wr gap", l_gap[b+1], GAP);
    endtask

    task automatic t_write_fixed();
        logic [31:0] rd;
        int b;
        b = n_log;
        do_op(2'd2, 32'hA5A5_3C3C, 1'b0, rd);
        check_half("R4 R5 wr fixed upper", b,   2'b11, 1'b0, 1'b0, 16'hA5A5, ACTIVE);
        check_half("R4 R5 wr fixed lower", b+1, 2'b11, 1'b1, 1'b0, 16'h3C3C, ACTIVE);
    endtask

    task automatic t_wait_ignored();
        logic [31:0] rd;
        int b;
        b = n_log;
        wait_all = 1'b1;
        do_op(2'd0, 32'h0048_0048, 1'b0, rd);
        do_op(2'd1, 32'h1100_2200, 1'b0, rd);
        wait_all = 1'b0;
        check_half("R8 ctrl upper", b,   2'b00, 1'b0, 1'b0, 16'h0048, ACTIVE);
        check_half("R8 ctrl lower", b+1, 2'b00, 1'b1, 1'b0, 16'h0048, ACTIVE);
        check_half("R8 addr upper", b+2, 2'b10, 1'b0, 1'b0, 16'h1100, ACTIVE);
        check_half("R8 addr lower", b+3, 2'b10, 1'b1, 1'b0, 16'h2200, ACTIVE);
        b = n_log;
        wait_first = 1'b1;
        do_op(2'd2, 32'h0F0F_F0F0, 1'b1, rd);
        wait_first = 1'b0;
        check_half("R8 data first half", b,   2'b01, 1'b0, 1'b0, 16'h0F0F, ACTIVE);
        check_half("R8 data second half", b+1, 2'b01, 1'b1, 1'b0, 16'hF0F0, ACTIVE);
    endtask

    task automatic t_read_wait();
        logic [31:0] rd;
        int b;
        b = n_log;
        rd_val = 32'hCAFE_BEEF;
        wait_cycles = 4;
        do_op(2'd3, 32'h0, 1'b1, rd);
        wait_cycles = 0;
        check("R6 read value", rd, 32'hCAFE_BEEF);
        check_half("R6 read upper", b,   2'b01, 1'b0, 1'b1, 16'hCAFE, ACTIVE);
        check_half("R6 R9 read lower", b+1, 2'b01, 1'b1, 1'b1, 16'hBEEF, 5);
    endtask

    task automatic t_read_fixed();
        logic [31:0] rd;
        int b;
        b = n_log;
        rd_val = 32'h0123_FEDC;
        do_op(2'd3, 32'hFFFF_FFFF, 1'b0, rd);
        check("R6 read fixed value", rd, 32'h0123_FEDC);
        check_half("R4 R6 read fixed lower", b+1, 2'b11, 1'b1, 1'b1, 16'hFEDC, ACTIVE);
        check("R6 host never drives on read", z_err, 0);
    endtask

    task automatic t_final();
        check("R7 lines stable while strobe low", stab_err, 0);
        check("R5 second strobe high", stb2_err, 0);
        check("R5 chip select low under strobe", cs_err, 0);
    endtask

    initial begin
        t_reset();
        t_init_addr();
        t_write_inc_wait();
        t_write_fixed();
        t_wait_ignored();
        t_read_wait();
        t_read_fixed();
        t_final();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule